// File: doc/BRIEF.md
# Banked Interface-Enable Control Register

This block holds a small control word that exists in two copies, one for the Secure world and one for the Non-secure world, together with the logic that decides the fate of every read or write aimed at it. The word carries three live fields: an enable that selects the system-register path to the interrupt controller, and two bits that turn off the bypass of the normal and fast interrupt lines when the controller is idle. All other bits are reserved.

Each request carries the current privilege level (0 to 3) and a non-secure select bit. The decision logic compares these with a hypervisor trap bit, two access-enable bits held at higher levels, debug state, and the interface-enable bits of the level 2 and level 3 registers. It returns one of three outcomes: the access completes, the access is an undefined instruction, or the access traps to a named level with a syndrome code. Build parameters say which levels exist, which bypass features exist, and whether only the system-register path is built. Some bits are then pinned to a fixed value, and writes to them are dropped.

Reads return data in the same cycle as the request. A write that completes takes effect on the next rising clock edge.

Top module: `banked_ctl_reg`

## Requirements
- R1: Bits 31 down to 3 of the read data are always zero, and the write data in those bits has no effect.
- R2: After reset, every stored field in both copies is 0. Bit 0 is the interface enable, bit 1 disables fast-interrupt bypass and bit 2 disables normal-interrupt bypass.
- R3: When the build lacks normal-interrupt bypass, bit 2 reads as one and writes to it are dropped. The same holds for fast-interrupt bypass and bit 1.
- R4: When the build has only the system-register path, bit 0 reads as one and writes to it are dropped. This takes priority over R5.
- R5: While the level 3 interface enable is 0 (and level 3 exists), bit 0 of both copies reads as zero and writes to it are dropped. While the level 2 interface enable is 0 (and level 2 exists), the same applies to bit 0 of the Non-secure copy only. The stored value survives and reappears once the enable returns to 1.
- R6: Any access at level 0 gives the undefined outcome.
- R7: At level 1, an access traps to level 2 with syndrome 0x03 when level 2 exists, `l2_enabled` is 1 and `l2_trap_en` is 1. In every other case it is undefined.
- R8: At level 2 the checks run in this order. If level 2 is absent, the access is undefined. Otherwise, if level 3 exists and `l3_access_en` is 0, the access traps to level 3 with syndrome 0x03, except that it is undefined when both `dbg_halted` and `dbg_secure_off` are 1. Otherwise, if `m32_access_en` is 0, the access is undefined. Otherwise it completes.
- R9: At level 3, an access completes when level 3 exists and is undefined otherwise.
- R10: When level 3 exists, `req_ns` = 0 selects the Secure copy and 1 selects the Non-secure copy. Without level 3, only the Non-secure copy is used.
- R11: `result` is 00 for complete, 01 for undefined and 10 for trap. With no request it is 00. `trap_level` and `syndrome` are zero unless the outcome is trap. `rdata` is zero unless a read completes.
- R12: Read data is combinational within the request cycle. A write updates the selected copy on the next rising edge, and only when its outcome is complete.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_level | input | 2 | Privilege level of the requester |
| req_ns | input | 1 | Non-secure select |
| req_wdata | input | 32 | Write data |
| l2_enabled | input | 1 | Level 2 is active for the requester |
| l2_trap_en | input | 1 | Hypervisor trap bit for this register |
| l3_access_en | input | 1 | Level 3 access-enable bit for lower levels |
| m32_access_en | input | 1 | 32-bit-mode access-enable bit |
| dbg_halted | input | 1 | Core is in debug halt |
| dbg_secure_off | input | 1 | Secure debug is disabled |
| l3_sre | input | 1 | Level 3 interface-enable bit |
| l2_sre | input | 1 | Level 2 interface-enable bit |
| rdata | output | 32 | Read data |
| result | output | 2 | Outcome code |
| trap_level | output | 2 | Target level of a trap |
| syndrome | output | 8 | Syndrome of a trap |

## Verification
The case that matters most is a write strobe that arrives in the same cycle as a non-complete outcome, or in the same cycle as a gate that pins bit 0. The bench provokes the first with write requests at level 1 while the trap bit is set, and at level 2 while the level 3 access enable is low. It then reads the copy back at level 3 and expects it unchanged. It provokes the second by writing zero while the level 3 interface enable is low: the bypass bits must clear, and the stored enable must reappear once the gate lifts. All outcomes are swept over every level and every combination of the six control inputs, for two build configurations.

// File: rtl/bcr_pkg.sv
package bcr_pkg;

  localparam int FIELD_W = 3;
  localparam int F_SRE   = 0;
  localparam int F_DFB   = 1;
  localparam int F_DIB   = 2;

  typedef enum logic [1:0] {
    RES_OK    = 2'b00,
    RES_UNDEF = 2'b01,
    RES_TRAP  = 2'b10
  } res_e;

  typedef struct packed {
    res_e       res;
    logic [1:0] tgt;
    logic [7:0] syn;
  } verdict_t;

  // Outcome of one access, from level and the gating state above it.
  function automatic verdict_t decide(
    input logic [1:0] lvl,
    input logic       has3,
    input logic       has2,
    input logic       l2en,
    input logic       l2trap,
    input logic       l3en,
    input logic       m32en,
    input logic       halted,
    input logic       sdd,
    input logic [7:0] code
  );
    verdict_t v;
    v = '{res: RES_UNDEF, tgt: 2'd0, syn: 8'd0};
    case (lvl)
      2'd1: if (has2 && l2en && l2trap) v = '{res: RES_TRAP, tgt: 2'd2, syn: code};
      2'd2: begin
        if (!has2)                   v.res = RES_UNDEF;
        else if (has3 && !l3en) begin
          if (!(halted && sdd))      v = '{res: RES_TRAP, tgt: 2'd3, syn: code};
        end
        else if (m32en)              v.res = RES_OK;
      end
      2'd3: if (has3) v.res = RES_OK;
      default: v.res = RES_UNDEF;
    endcase
    return v;
  endfunction

  // Visible field value: forced-zero bits cleared, forced-one bits set (one wins).
  function automatic logic [FIELD_W-1:0] show_bits(
    input logic [FIELD_W-1:0] stored,
    input logic [FIELD_W-1:0] one_m,
    input logic [FIELD_W-1:0] zero_m
  );
    return (stored & ~zero_m) | one_m;
  endfunction

  // Next stored value: write-ignored bits keep their old contents.
  function automatic logic [FIELD_W-1:0] merge_write(
    input logic [FIELD_W-1:0] stored,
    input logic [FIELD_W-1:0] wd,
    input logic [FIELD_W-1:0] wi_m
  );
    return (stored & wi_m) | (wd & ~wi_m);
  endfunction

endpackage

// File: rtl/bcr_arbiter.sv
module bcr_arbiter
  import bcr_pkg::*;
#(
  parameter bit         HAS_L3    = 1'b1,
  parameter bit         HAS_L2    = 1'b1,
  parameter logic [7:0] TRAP_CODE = 8'h03
) (
  input  logic       req_valid,
  input  logic [1:0] lvl,
  input  logic       ns,
  input  logic       l2_en,
  input  logic       l2_trap,
  input  logic       l3_acc_en,
  input  logic       m32_acc_en,
  input  logic       halted,
  input  logic       sdd,
  output verdict_t   verdict,
  output logic       sel
);

  always_comb begin
    verdict = '{res: RES_OK, tgt: 2'd0, syn: 8'd0};
    if (req_valid)
      verdict = decide(lvl, HAS_L3, HAS_L2, l2_en, l2_trap, l3_acc_en,
                       m32_acc_en, halted, sdd, TRAP_CODE);
  end

  generate
    if (HAS_L3) begin : g_banked
      assign sel = ns;
    end else begin : g_single
      assign sel = 1'b1;
    end
  endgenerate

endmodule

// File: rtl/bcr_view.sv
module bcr_view
  import bcr_pkg::*;
#(
  parameter bit IS_NS       = 1'b0,
  parameter bit HAS_L3      = 1'b1,
  parameter bit HAS_L2      = 1'b1,
  parameter bit IRQ_BYP_OK  = 1'b1,
  parameter bit FIQ_BYP_OK  = 1'b1,
  parameter bit SYSREG_ONLY = 1'b0
) (
  input  logic [FIELD_W-1:0] stored,
  input  logic               l3_sre,
  input  logic               l2_sre,
  output logic [FIELD_W-1:0] shown,
  output logic [FIELD_W-1:0] wi_mask
);

  localparam logic [FIELD_W-1:0] ONE_M =
    (FIELD_W'(!IRQ_BYP_OK) << F_DIB) |
    (FIELD_W'(!FIQ_BYP_OK) << F_DFB) |
    (FIELD_W'(SYSREG_ONLY) << F_SRE);

  logic               sre_gated;
  logic [FIELD_W-1:0] zero_m;

  always_comb begin
    sre_gated = (HAS_L3 && !l3_sre) || (IS_NS && HAS_L2 && !l2_sre);
    zero_m    = FIELD_W'(sre_gated) << F_SRE;
    shown     = show_bits(stored, ONE_M, zero_m);
    wi_mask   = ONE_M | zero_m;
  end

endmodule

// File: rtl/bcr_store.sv
module bcr_store
  import bcr_pkg::*;
#(
  parameter int COPIES = 2
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [COPIES-1:0]               we,
  input  logic [COPIES-1:0][FIELD_W-1:0]  nxt,
  output logic [COPIES-1:0][FIELD_W-1:0]  q
);

  for (genvar g = 0; g < COPIES; g++) begin : g_copy
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q[g] <= '0;
      else if (we[g]) q[g] <= nxt[g];
    end
  end

  AST_CLEAR_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> q == '0); // R2

endmodule

// File: rtl/banked_ctl_reg.sv
module banked_ctl_reg
  import bcr_pkg::*;
#(
  parameter int         DATA_W      = 32,
  parameter bit         HAS_L3      = 1'b1,
  parameter bit         HAS_L2      = 1'b1,
  parameter bit         IRQ_BYP_OK  = 1'b1,
  parameter bit         FIQ_BYP_OK  = 1'b1,
  parameter bit         SYSREG_ONLY = 1'b0,
  parameter logic [7:0] TRAP_CODE   = 8'h03
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [1:0]        req_level,
  input  logic              req_ns,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              l2_enabled,
  input  logic              l2_trap_en,
  input  logic              l3_access_en,
  input  logic              m32_access_en,
  input  logic              dbg_halted,
  input  logic              dbg_secure_off,
  input  logic              l3_sre,
  input  logic              l2_sre,
  output logic [DATA_W-1:0] rdata,
  output logic [1:0]        result,
  output logic [1:0]        trap_level,
  output logic [7:0]        syndrome
);

  localparam int COPIES = 2;
  localparam int PAD_W  = DATA_W - FIELD_W;

  verdict_t                          vd;
  logic                              sel;
  logic                              wr_commit;
  logic                              rd_ok;
  logic [COPIES-1:0]                 we;
  logic [COPIES-1:0][FIELD_W-1:0]    store_q;
  logic [COPIES-1:0][FIELD_W-1:0]    store_nxt;
  logic [COPIES-1:0][FIELD_W-1:0]    shown;
  logic [COPIES-1:0][FIELD_W-1:0]    wi_mask;

  bcr_arbiter #(
    .HAS_L3    (HAS_L3),
    .HAS_L2    (HAS_L2),
    .TRAP_CODE (TRAP_CODE)
  ) u_arb (
    .req_valid  (req_valid),
    .lvl        (req_level),
    .ns         (req_ns),
    .l2_en      (l2_enabled),
    .l2_trap    (l2_trap_en),
    .l3_acc_en  (l3_access_en),
    .m32_acc_en (m32_access_en),
    .halted     (dbg_halted),
    .sdd        (dbg_secure_off),
    .verdict    (vd),
    .sel        (sel)
  );

  for (genvar g = 0; g < COPIES; g++) begin : g_bank
    bcr_view #(
      .IS_NS       (g == 1),
      .HAS_L3      (HAS_L3),
      .HAS_L2      (HAS_L2),
      .IRQ_BYP_OK  (IRQ_BYP_OK),
      .FIQ_BYP_OK  (FIQ_BYP_OK),
      .SYSREG_ONLY (SYSREG_ONLY)
    ) u_view (
      .stored  (store_q[g]),
      .l3_sre  (l3_sre),
      .l2_sre  (l2_sre),
      .shown   (shown[g]),
      .wi_mask (wi_mask[g])
    );
    assign we[g]        = wr_commit && (sel == 1'(g));
    assign store_nxt[g] = merge_write(store_q[g], req_wdata[FIELD_W-1:0], wi_mask[g]);
  end

  bcr_store #(.COPIES(COPIES)) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (we),
    .nxt   (store_nxt),
    .q     (store_q)
  );

  assign wr_commit  = req_valid &&  req_write && (vd.res == RES_OK);
  assign rd_ok      = req_valid && !req_write && (vd.res == RES_OK);
  assign rdata      = rd_ok ? {{PAD_W{1'b0}}, shown[sel]} : '0;
  assign result     = vd.res;
  assign trap_level = vd.tgt;
  assign syndrome   = vd.syn;

  AST_RES0_READ: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> rdata[DATA_W-1:FIELD_W] == '0); // R1
  AST_WRITE_NO_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && (|req_wdata[DATA_W-1:FIELD_W])) |-> rdata == '0); // R11
  AST_L0_UNDEF: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_level == 2'd0) |-> result == RES_UNDEF); // R6
  AST_TRAP_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
    (result == RES_TRAP) |-> (syndrome == TRAP_CODE && trap_level[1])); // R11
  AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> (result == RES_OK && rdata == '0 && syndrome == 8'd0)); // R11
  AST_HOLD_ON_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && result != RES_OK) |=> $stable(store_q)); // R12
  AST_SRE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ok && HAS_L3 && !SYSREG_ONLY && !l3_sre) |-> rdata[F_SRE] == 1'b0); // R5
  AST_SRE_PINNED: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ok && SYSREG_ONLY) |-> rdata[F_SRE] == 1'b1); // R4

endmodule

// File: tb/sim_banked_ctl_reg.sv
module sim_banked_ctl_reg;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_ns = 1'b0;
  logic [1:0]  req_level = 2'd0;
  logic [31:0] req_wdata = '0;
  logic        l2_enabled = 0, l2_trap_en = 0, l3_access_en = 1, m32_access_en = 1;
  logic        dbg_halted = 0, dbg_secure_off = 0, l3_sre = 1, l2_sre = 1;
  logic [31:0] rd0, rd1;
  logic [1:0]  res0, res1, tl0, tl1;
  logic [7:0]  syn0, syn1;
  int          errors = 0, checks = 0;

  always #5 clk = ~clk;

  // u0: both levels, full bypass support, both interface paths.
  banked_ctl_reg u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_level(req_level), .req_ns(req_ns), .req_wdata(req_wdata),
    .l2_enabled(l2_enabled), .l2_trap_en(l2_trap_en), .l3_access_en(l3_access_en),
    .m32_access_en(m32_access_en), .dbg_halted(dbg_halted), .dbg_secure_off(dbg_secure_off),
    .l3_sre(l3_sre), .l2_sre(l2_sre),
    .rdata(rd0), .result(res0), .trap_level(tl0), .syndrome(syn0));

  // u1: no level 3, no bypass support, system-register path only.
  banked_ctl_reg #(.HAS_L3(1'b0), .IRQ_BYP_OK(1'b0), .FIQ_BYP_OK(1'b0), .SYSREG_ONLY(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_level(req_level), .req_ns(req_ns), .req_wdata(req_wdata),
    .l2_enabled(l2_enabled), .l2_trap_en(l2_trap_en), .l3_access_en(l3_access_en),
    .m32_access_en(m32_access_en), .dbg_halted(dbg_halted), .dbg_secure_off(dbg_secure_off),
    .l3_sre(l3_sre), .l2_sre(l2_sre),
    .rdata(rd1), .result(res1), .trap_level(tl1), .syndrome(syn1));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Expected outcome {result, target, syndrome}, restated from R6 to R9.
  function automatic logic [11:0] model(input bit h3, input bit h2, input int lvl,
      input bit e2, input bit t2, input bit a3, input bit a32, input bit hl, input bit sd);
    logic [1:0] r = 2'd1;
    logic [1:0] tg = 2'd0;
    logic [7:0] sy = 8'd0;
    if (lvl == 1 && h2 && e2 && t2) begin r = 2'd2; tg = 2'd2; sy = 8'h03; end
    if (lvl == 2 && h2) begin
      if (h3 && !a3 && !(hl && sd)) begin r = 2'd2; tg = 2'd3; sy = 8'h03; end
      else if ((!h3 || a3) && a32)  r = 2'd0;
    end
    if (lvl == 3 && h3) r = 2'd0;
    return {r, tg, sy};
  endfunction

  task automatic drive(input bit w, input logic [1:0] lvl, input bit ns, input logic [31:0] d);
    req_valid = 1'b1; req_write = w; req_level = lvl; req_ns = ns; req_wdata = d;
    #2;
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // Reset state (R2) and pinned bits on u1 (R3, R4).
    @(negedge clk); drive(0, 2'd3, 0, 0);
    chk("R2 secure copy after reset", rd0, 32'h0);
    @(negedge clk); drive(0, 2'd3, 1, 0);
    chk("R2 nonsecure copy after reset", rd0, 32'h0);
    @(negedge clk); drive(0, 2'd2, 0, 0);
    chk("R3 R4 u1 pinned ones", rd1, 32'h7);

    // Outcome sweep over every level and gate combination (R6 R7 R8 R9 R11).
    for (int lv = 0; lv < 4; lv++) begin
      for (int m = 0; m < 64; m++) begin
        logic [11:0] e0, e1;
        @(negedge clk);
        {l2_enabled, l2_trap_en, l3_access_en, m32_access_en, dbg_halted, dbg_secure_off} = 6'(m);
        drive(0, 2'(lv), 0, 0);
        e0 = model(1, 1, lv, m[5], m[4], m[3], m[2], m[1], m[0]);
        e1 = model(0, 1, lv, m[5], m[4], m[3], m[2], m[1], m[0]);
        chk("R6 R7 R8 R9 outcome u0", {20'd0, res0, tl0, syn0}, {20'd0, e0});
        chk("R7 R8 R9 outcome u1", {20'd0, res1, tl1, syn1}, {20'd0, e1});
        chk("R11 rdata u0", rd0, (e0[11:10] == 2'd0) ? 32'h0 : 32'h0);
        chk("R11 rdata u1", rd1, (e1[11:10] == 2'd0) ? 32'h7 : 32'h0);
      end
    end

    // Banked writes at level 3 (R1 R10 R12).
    @(negedge clk);
    l2_enabled = 1; l2_trap_en = 0; l3_access_en = 1; m32_access_en = 1;
    dbg_halted = 0; dbg_secure_off = 0;
    drive(1, 2'd3, 0, 32'hFFFF_FFFF);
    chk("R11 write returns zero data", rd0, 32'h0);
    @(negedge clk); drive(0, 2'd3, 0, 0);
    chk("R1 R12 secure copy written", rd0, 32'h7);
    @(negedge clk); drive(0, 2'd3, 1, 0);
    chk("R10 nonsecure copy untouched", rd0, 32'h0);
    @(negedge clk); drive(1, 2'd3, 1, 32'hFFFF_FFF5);
    @(negedge clk); drive(0, 2'd3, 1, 0);
    chk("R1 R10 nonsecure copy written", rd0, 32'h5);
    req_ns = 1'b0; #2;
    chk("R12 combinational read same cycle", rd0, 32'h7);

    // Write strobe with a trap outcome (R12 R7 R8).
    @(negedge clk); l2_trap_en = 1; drive(1, 2'd1, 0, 32'h0);
    chk("R7 level1 write traps", {30'd0, res0}, 32'h2);
    @(negedge clk); l2_trap_en = 0; l3_access_en = 0; drive(1, 2'd2, 0, 32'h0);
    chk("R8 level2 write traps to 3", {30'd0, tl0}, 32'h3);
    @(negedge clk); l3_access_en = 1; drive(0, 2'd3, 0, 0);
    chk("R12 trapped writes dropped", rd0, 32'h7);

    // Gated interface enable (R5).
    @(negedge clk); l3_sre = 0; drive(0, 2'd3, 0, 0);
    chk("R5 secure bit0 gated by level3", rd0, 32'h6);
    @(negedge clk); drive(0, 2'd3, 1, 0);
    chk("R5 nonsecure bit0 gated by level3", rd0, 32'h4);
    @(negedge clk); drive(1, 2'd3, 0, 32'h0);
    @(negedge clk); drive(0, 2'd3, 0, 0);
    chk("R5 bypass bits written while gated", rd0, 32'h0);
    @(negedge clk); l3_sre = 1; drive(0, 2'd3, 0, 0);
    chk("R5 stored enable survives gating", rd0, 32'h1);
    @(negedge clk); l2_sre = 0; drive(0, 2'd3, 1, 0);
    chk("R5 nonsecure bit0 gated by level2", rd0, 32'h4);
    @(negedge clk); drive(0, 2'd3, 0, 0);
    chk("R5 secure copy ignores level2 gate", rd0, 32'h1);

    // Level 2 complete path and u1 write-ignore (R8 R10 R3 R4).
    @(negedge clk); l2_sre = 1; drive(0, 2'd2, 1, 0);
    chk("R8 R10 level2 read nonsecure", rd0, 32'h5);
    chk("R10 u1 single copy read", rd1, 32'h7);
    @(negedge clk); drive(1, 2'd2, 1, 32'h0);
    @(negedge clk); drive(0, 2'd2, 1, 0);
    chk("R3 R4 u1 writes ignored", rd1, 32'h7);
    chk("R12 u0 nonsecure cleared", rd0, 32'h0);

    // Idle (R11).
    @(negedge clk); req_valid = 0; req_write = 0; #2;
    chk("R11 idle outcome", {28'd0, res0, res1}, 32'h0);
    chk("R11 idle rdata", rd0 | rd1, 32'h0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule